// File: doc/BRIEF.md
# Transition-Coded Bus Link

This block carries a stream of bytes across a long on-chip bus while trying to toggle as few wires as possible. The sending side remembers the last byte it accepted. It looks up the pair (last byte, new byte) in a small ranked table. When the pair is found, the sender does not put the byte itself on the wires. It XORs the entry's code onto the value the wires already hold, so only the 1 bits of the code make wires switch. Frequent transitions are given codes with few 1 bits. A ninth wire, the coded flag, tells the receiver which kind of word it is seeing.

The receiving side keeps its own copy of the table, the last byte it decoded and the last word it saw on the wires. For a coded word it takes received wires XOR previous wires, which gives back the code. It then finds the entry whose previous byte and code both match, and outputs that entry's current byte. An uncoded word is passed through unchanged. A single write port loads the same entry into both table copies in the same clock. The port is meant to be used only while no bytes are being sent. Building the table from traffic profiles is done elsewhere.

Top module: `tcode_link`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, bus_data = 0, bus_flag = 0, bus_valid = 0, out_valid = 0 and out_data = 0. Every table entry becomes invalid.
- R2: A byte accepted with in_valid = 1 whose (previous byte, byte) pair matches a valid entry appears one clock later as bus_flag = 1 and bus_data = (bus_data before that edge) XOR the entry's code, with bus_valid = 1.
- R3: An accepted byte with no matching valid entry appears one clock later as bus_data = the byte itself and bus_flag = 0, with bus_valid = 1.
- R4: The lookup key is the previously accepted byte together with the current byte. The previous byte is 0 after reset. A current byte that follows a different previous byte does not match.
- R5: In a clock with in_valid = 0, bus_valid is 0 afterwards, bus_data and bus_flag keep their values, and the remembered previous byte does not change.
- R6: Each accepted byte reappears on out_data with out_valid = 1 exactly two clocks after it was accepted. out_valid is 0 in every other clock.
- R7: Each coded word toggles exactly popcount(code) of the eight data wires.
- R8: When several valid entries match the same pair, the one with the lowest index supplies the code.
- R9: An entry written with valid = 0 never matches. A write replaces all fields of the entry. A write to an index of K_ENTRIES or above changes nothing.
- R10: The table write port (tbl_we, tbl_idx and the entry fields) loads the encoder and decoder copies in the same clock. The write takes effect for bytes accepted in later clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_vld | input | 1 | Valid bit for the entry |
| tbl_prev | input | 8 | Previous byte of the transition |
| tbl_cur | input | 8 | Current byte of the transition |
| tbl_code | input | 8 | Code sent for the transition |
| in_valid | input | 1 | Byte offered this clock |
| in_data | input | 8 | Byte to send |
| bus_data | output | 8 | Eight data wires of the bus |
| bus_flag | output | 1 | Coded-word wire |
| bus_valid | output | 1 | Bus word is new this clock |
| out_valid | output | 1 | Decoded byte is valid |
| out_data | output | 8 | Decoded byte |

## Verification
The bench keeps a behavioural model of the table and of the wire state and compares all outputs every clock. It aims at the following cases:
- A first byte that hits against the reset previous value of 0. A design that seeds the previous byte differently would send it raw.
- The same current byte after a different previous byte. A design keyed only on the current byte would code it.
- Idle gaps between coded words. A design that moves its state during gaps would XOR against the wrong base and decode garbage.
- Duplicate matches, invalidated entries, overwrites and out-of-range writes. Wrong priority or a stale entry shows up as the wrong wire value.
- A zero code, and a long mixed stream. Any mismatch between the encoder and decoder copies breaks the round trip.

// File: rtl/tcode_pkg.sv
// Shared types for the transition-coded bus link.
// Assumes a byte-wide data bus; one table entry describes one transition.
package tcode_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  vld;
        byte_t prev;
        byte_t cur;
        byte_t code;
    } entry_t;
endpackage

// File: rtl/tcode_table.sv
// Ranked transition table: K_ENTRIES registers loaded through one write port.
// Assumes writes happen while the link is idle; out-of-range indices are dropped.
module tcode_table
    import tcode_pkg::*;
#(
    parameter int unsigned K_ENTRIES = 9,
    parameter int unsigned IDX_W     = (K_ENTRIES > 1) ? $clog2(K_ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  entry_t                  wr_entry,
    output entry_t [K_ENTRIES-1:0]  ents
);
    for (genvar g = 0; g < K_ENTRIES; g++) begin : g_ent
        // Hold one entry; cleared on reset, replaced whole on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ents[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                ents[g] <= wr_entry;
        end
    end
endmodule

// File: rtl/tcode_encoder.sv
// Sender side: looks up (previous byte, byte) and drives the nine bus wires.
// Assumes at most one code per pair is wanted; the lowest matching index wins.
module tcode_encoder
    import tcode_pkg::*;
#(
    parameter int unsigned K_ENTRIES = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  entry_t [K_ENTRIES-1:0]  ents,
    input  logic                    in_valid,
    input  byte_t                   in_data,
    output byte_t                   bus_data,
    output logic                    bus_flag,
    output logic                    bus_valid
);
    byte_t prev_q;
    logic  hit;
    byte_t code;

    // Priority search over the table, lowest index last so it wins.
    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int i = K_ENTRIES - 1; i >= 0; i--) begin
            if (ents[i].vld && ents[i].prev == prev_q && ents[i].cur == in_data) begin
                hit  = 1'b1;
                code = ents[i].code;
            end
        end
    end

    // Drive the wires: XOR the code on a hit, the raw byte on a miss, hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            bus_data  <= '0;
            bus_flag  <= 1'b0;
            bus_valid <= 1'b0;
        end else begin
            bus_valid <= in_valid;
            if (in_valid) begin
                prev_q   <= in_data;
                bus_flag <= hit;
                bus_data <= hit ? (bus_data ^ code) : in_data;
            end
        end
    end
endmodule

// File: rtl/tcode_decoder.sv
// Receiver side: recovers the code from wire changes and maps it back to a byte.
// Assumes codes are unique among entries sharing a previous byte.
module tcode_decoder
    import tcode_pkg::*;
#(
    parameter int unsigned K_ENTRIES = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  entry_t [K_ENTRIES-1:0]  ents,
    input  byte_t                   bus_data,
    input  logic                    bus_flag,
    input  logic                    bus_valid,
    output logic                    out_valid,
    output byte_t                   out_data
);
    byte_t last_q;
    byte_t wire_q;
    byte_t rx_code;
    logic  hit;
    byte_t hit_cur;
    byte_t decoded;

    assign rx_code = bus_data ^ wire_q;

    // Find the entry whose previous byte and code both match, lowest index wins.
    always_comb begin
        hit     = 1'b0;
        hit_cur = '0;
        for (int i = K_ENTRIES - 1; i >= 0; i--) begin
            if (ents[i].vld && ents[i].prev == last_q && ents[i].code == rx_code) begin
                hit     = 1'b1;
                hit_cur = ents[i].cur;
            end
        end
    end

    // Select the decoded byte: the table byte for coded words, else the wires.
    always_comb begin
        decoded = (bus_flag && hit) ? hit_cur : bus_data;
    end

    // Register the result and track the last byte and the last wire value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q    <= '0;
            wire_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= bus_valid;
            if (bus_valid) begin
                last_q   <= decoded;
                wire_q   <= bus_data;
                out_data <= decoded;
            end
        end
    end
endmodule

// File: rtl/tcode_link.sv
// Top: encoder and decoder, each with its own table copy fed by one write port.
// Assumes tbl_we is raised only while no bytes are in flight.
module tcode_link
    import tcode_pkg::*;
#(
    parameter int unsigned K_ENTRIES = 9,
    parameter int unsigned IDX_W     = (K_ENTRIES > 1) ? $clog2(K_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic             tbl_vld,
    input  logic [7:0]       tbl_prev,
    input  logic [7:0]       tbl_cur,
    input  logic [7:0]       tbl_code,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic [7:0]       bus_data,
    output logic             bus_flag,
    output logic             bus_valid,
    output logic             out_valid,
    output logic [7:0]       out_data
);
    entry_t                 wr_entry;
    entry_t [K_ENTRIES-1:0] enc_ents;
    entry_t [K_ENTRIES-1:0] dec_ents;

    // Pack the write-port fields into one entry.
    always_comb begin
        wr_entry = '{vld: tbl_vld, prev: tbl_prev, cur: tbl_cur, code: tbl_code};
    end

    tcode_table #(.K_ENTRIES(K_ENTRIES), .IDX_W(IDX_W)) i_enc_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
        .wr_entry(wr_entry), .ents(enc_ents)
    );

    tcode_table #(.K_ENTRIES(K_ENTRIES), .IDX_W(IDX_W)) i_dec_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
        .wr_entry(wr_entry), .ents(dec_ents)
    );

    tcode_encoder #(.K_ENTRIES(K_ENTRIES)) i_enc (
        .clk(clk), .rst_n(rst_n), .ents(enc_ents),
        .in_valid(in_valid), .in_data(in_data),
        .bus_data(bus_data), .bus_flag(bus_flag), .bus_valid(bus_valid)
    );

    tcode_decoder #(.K_ENTRIES(K_ENTRIES)) i_dec (
        .clk(clk), .rst_n(rst_n), .ents(dec_ents),
        .bus_data(bus_data), .bus_flag(bus_flag), .bus_valid(bus_valid),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/tcode_link_chk.sv
// Checker for tcode_link: port-level timing and hold properties.
// Assumes it is bound to every instance of the top module.
module tcode_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic [7:0] bus_data,
    input logic       bus_flag,
    input logic       bus_valid,
    input logic       out_valid,
    input logic [7:0] out_data
);
    assert_miss_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_flag) |-> (bus_data == $past(in_data)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(bus_data) && $stable(bus_flag) && !bus_valid));

    assert_out_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    assert_out_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid ##2 out_valid) |-> (out_data == $past(in_data, 2)));
endmodule

bind tcode_link tcode_link_chk i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_data(bus_data), .bus_flag(bus_flag), .bus_valid(bus_valid),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_tcode_link.sv
module test_tcode_link;
    localparam int K = 9;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic          tbl_vld = 1'b0;
    logic [7:0]    tbl_prev = '0, tbl_cur = '0, tbl_code = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic [7:0]    bus_data;
    logic          bus_flag, bus_valid, out_valid;
    logic [7:0]    out_data;

    always #5 clk = ~clk;

    tcode_link #(.K_ENTRIES(K), .IDX_W(IW)) i_tcode_link (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_vld(tbl_vld), .tbl_prev(tbl_prev), .tbl_cur(tbl_cur), .tbl_code(tbl_code),
        .in_valid(in_valid), .in_data(in_data),
        .bus_data(bus_data), .bus_flag(bus_flag), .bus_valid(bus_valid),
        .out_valid(out_valid), .out_data(out_data)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state
    bit       mv[K];
    bit [7:0] mp[K], mc[K], mk[K];
    bit [7:0] m_prev = 0, m_bus = 0;
    bit       m_flag = 0;
    bit       last_v = 0;
    bit [7:0] last_d = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input bit [7:0] p, input bit [7:0] c, output bit hit, output bit [7:0] code);
        hit = 0; code = 0;
        for (int i = 0; i < K; i++)
            if (!hit && mv[i] && mp[i] == p && mc[i] == c) begin
                hit = 1; code = mk[i];
            end
    endtask

    // One clock: apply inputs at negedge, check all outputs at the next negedge.
    task automatic xfer(input bit v, input bit [7:0] d, input string req);
        bit       hit;
        bit [7:0] code, exp_bus, old_bus;
        bit       exp_flag;
        in_valid = v; in_data = d;
        hit = 0; code = 0; old_bus = m_bus; exp_bus = m_bus; exp_flag = m_flag;
        if (v) begin
            lookup(m_prev, d, hit, code);
            exp_bus  = hit ? (m_bus ^ code) : d;
            exp_flag = hit;
        end
        @(negedge clk);
        chk({req, " bus_valid"}, int'(bus_valid), int'(v));
        chk({req, " bus_data"}, int'(bus_data), int'(exp_bus));
        chk({req, " bus_flag"}, int'(bus_flag), int'(exp_flag));
        if (v && hit) // R7: toggles equal code weight
            chk("R7 toggles", $countones(bus_data ^ old_bus), $countones(code));
        chk("R6 out_valid", int'(out_valid), int'(last_v));
        if (last_v) chk("R6 out_data", int'(out_data), int'(last_d));
        if (v) m_prev = d;
        m_bus = exp_bus; m_flag = exp_flag;
        last_v = v; last_d = d;
        in_valid = 0;
    endtask

    task automatic twrite(input int idx, input bit vl, input bit [7:0] p, input bit [7:0] c,
                          input bit [7:0] k);
        tbl_we = 1; tbl_idx = IW'(idx); tbl_vld = vl; tbl_prev = p; tbl_cur = c; tbl_code = k;
        xfer(0, 8'h00, "R10 write idle");
        tbl_we = 0;
        if (idx < K) begin
            mv[idx] = vl; mp[idx] = p; mc[idx] = c; mk[idx] = k;
        end
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < K; i++) begin mv[i] = 0; mp[i] = 0; mc[i] = 0; mk[i] = 0; end
        in_valid = 1; in_data = 8'h5A; // ignored during reset
        repeat (3) @(negedge clk);
        chk("R1 bus_data", int'(bus_data), 0);
        chk("R1 bus_flag", int'(bus_flag), 0);
        chk("R1 bus_valid", int'(bus_valid), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_data", int'(out_data), 0);
        in_valid = 0;
        rst_n = 1;

        // R10: load table; R8 duplicate at 4; R9 invalid at 5
        twrite(0, 1, 8'h00, 8'h41, 8'h01);
        twrite(1, 1, 8'h41, 8'h42, 8'h02);
        twrite(2, 1, 8'h42, 8'h43, 8'h00);
        twrite(3, 1, 8'h43, 8'h41, 8'h80);
        twrite(4, 1, 8'h41, 8'h42, 8'h03);
        twrite(5, 0, 8'h50, 8'h51, 8'h01);
        twrite(6, 1, 8'h10, 8'h20, 8'h01);
        twrite(7, 1, 8'h20, 8'h20, 8'h10);
        twrite(8, 1, 8'h55, 8'hAA, 8'h0F);
        twrite(12, 1, 8'hAA, 8'h41, 8'h01); // R9 out of range, dropped

        xfer(1, 8'h41, "R4 first from 0");
        xfer(1, 8'h42, "R8 priority");
        xfer(1, 8'h43, "R2 zero code");
        xfer(1, 8'h41, "R2 hit");
        xfer(0, 8'h00, "R5 idle");
        xfer(0, 8'h77, "R5 idle");
        xfer(1, 8'h42, "R5 after gap");
        xfer(1, 8'h50, "R3 miss");
        xfer(1, 8'h51, "R9 invalid");
        xfer(1, 8'h10, "R3 miss");
        xfer(1, 8'h20, "R2 hit");
        xfer(1, 8'h20, "R2 repeat");
        xfer(1, 8'h30, "R3 miss");
        xfer(1, 8'h20, "R4 other prev");
        xfer(1, 8'h55, "R3 miss");
        xfer(1, 8'hAA, "R7 heavy code");
        xfer(1, 8'h41, "R9 out of range");
        xfer(0, 8'h00, "R5 idle");
        twrite(1, 0, 8'h41, 8'h42, 8'h02);
        xfer(1, 8'h43, "R3 miss");
        xfer(1, 8'h41, "R2 hit");
        xfer(1, 8'h42, "R9 overwrite");
        twrite(2, 1, 8'h42, 8'h11, 8'h40);
        xfer(1, 8'h11, "R9 replaced");

        // Mixed stream biased toward table transitions
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 9);
            bit [7:0] d;
            case (r)
                0: d = 8'h41; 1: d = 8'h42; 2: d = 8'h43; 3: d = 8'h20;
                4: d = 8'h10; 5: d = 8'h55; 6: d = 8'hAA; 7: d = 8'h11;
                default: d = 8'($urandom);
            endcase
            xfer($urandom_range(0, 5) != 0, d, "R6 stream");
        end
        xfer(0, 8'h00, "R6 drain");
        xfer(0, 8'h00, "R6 drain");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule